// File: doc/BRIEF.md
# Bit-Serial SIMD Element Array with Per-Element Indirect Addressing

This block is a row of bit-serial processing elements that all obey one instruction broadcast to them in the same clock cycle. Each element holds a private memory of one-bit words, a one-bit ALU with a carry flag and an operand flag, an activity bit, and a 16-bit shift register. The shift register lets each element form its own memory address.

Each instruction names a global bit address. It also names one of three address modes. In global mode every element uses the broadcast address. In replace mode each element uses the low address bits of its own shift register. In offset mode each element adds the low bits of its register to the broadcast address. An element loads its register one bit per cycle by shifting the ALU result into it. A 16-bit index is usually streamed out of the element's own memory over 16 instructions.

An activity bit masks each element. While the bit is clear, the element ignores the broadcast instruction. A per-element external bit serves as an alternative ALU operand, so that memory planes can be loaded with distinct data.

Top module: `simd_ind_array`

## Requirements
- R1: After reset, all activity bits read 1, and every indirection register, carry flag and operand flag is 0. Memory contents stay undefined until written.
- R2: With addr_mode_i = 0 or 3 (global), every element reads and writes its memory at gaddr_i.
- R3: With addr_mode_i = 1 (replace), each element uses bits [9:0] of its own indirection register as the address. Bits [15:10] have no effect on the address.
- R4: With addr_mode_i = 2 (offset), each element uses (gaddr_i + register bits [9:0]) mod 1024 as the address.
- R5: While ind_shift_i is 1, an active element updates its register to {res, reg[15:1]} at the clock edge. Sixteen shifts therefore leave the first bit shifted in at bit 0, so the register is loaded LSB first.
- R6: The ALU result res_o is computed from operand A (the memory bit rd_o) and operand B (the operand flag), selected by alu_op_i: 0 gives A, 1 gives A AND B, 2 gives A OR B, 3 gives A XOR B. Codes 6 and 7 behave as code 0.
- R7: alu_op_i = 4 is a full add, with res = A XOR B XOR carry. An active element then updates carry to the majority of A, B and carry. carry_clr_i clears carry in every element, and it takes priority over the add.
- R8: While flag_ld_i is 1, an active element loads its operand flag from res at the clock edge.
- R9: act_ld_i loads each element's activity bit from its res, whatever the current activity. An element whose activity bit is 0 does not change its memory, register, operand flag or carry, except for the clear in R7.
- R10: While mem_we_i is 1, an active element writes res into its memory at the effective address, and reads there return it from the next cycle on.
- R11: alu_op_i = 5 makes res equal to the element's ext_i bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_op_i | input | 3 | Broadcast ALU operation |
| addr_mode_i | input | 2 | Broadcast address mode: 0 global, 1 replace, 2 offset |
| gaddr_i | input | 10 | Broadcast global bit address |
| mem_we_i | input | 1 | Write res to memory |
| ind_shift_i | input | 1 | Shift res into the indirection register |
| flag_ld_i | input | 1 | Load the operand flag from res |
| act_ld_i | input | 1 | Load the activity bit from res |
| carry_clr_i | input | 1 | Clear all carry flags |
| ext_i | input | NUM_PE | Per-element external operand bit |
| rd_o | output | NUM_PE | Memory bit at each element's effective address |
| res_o | output | NUM_PE | Each element's ALU result |
| act_o | output | NUM_PE | Each element's activity bit |

## Verification
On every cycle, the assertions check the following. An activity bit changes only when a load is commanded. A pass-through result equals the memory bit that was read. An external-operand result equals the element's external bit. A write followed by a global read at the same address returns the written bit. Only the bench scenarios can show the rest. These are the per-element addresses formed in replace and offset modes, including wrap-around past 1023 and the ignored upper register bits. They also include the LSB-first register load, carry chaining, and the masking of inactive elements. A behavioural model checks these against the outputs every clock.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [2:0] OP_PASS = 3'd0;
  localparam logic [2:0] OP_AND  = 3'd1;
  localparam logic [2:0] OP_OR   = 3'd2;
  localparam logic [2:0] OP_XOR  = 3'd3;
  localparam logic [2:0] OP_ADD  = 3'd4;
  localparam logic [2:0] OP_EXT  = 3'd5;

  localparam logic [1:0] AM_GLOBAL  = 2'd0;
  localparam logic [1:0] AM_REPLACE = 2'd1;
  localparam logic [1:0] AM_OFFSET  = 2'd2;

  typedef enum logic [1:0] {FN_A, FN_AND, FN_OR, FN_XOR} logic_fn_e;

  typedef struct packed {
    logic      use_ind;
    logic      add_glob;
    logic      sel_ext;
    logic_fn_e fn;
    logic      is_add;
    logic      we;
    logic      shift;
    logic      flag_ld;
    logic      act_ld;
    logic      carry_clr;
  } pe_ctrl_t;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [2:0] alu_op_i,
  input  logic [1:0] addr_mode_i,
  input  logic       mem_we_i,
  input  logic       ind_shift_i,
  input  logic       flag_ld_i,
  input  logic       act_ld_i,
  input  logic       carry_clr_i,
  output pe_ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o           = '0;
    ctrl_o.fn        = FN_A;
    ctrl_o.use_ind   = (addr_mode_i == AM_REPLACE) || (addr_mode_i == AM_OFFSET);
    ctrl_o.add_glob  = (addr_mode_i == AM_OFFSET);
    ctrl_o.we        = mem_we_i;
    ctrl_o.shift     = ind_shift_i;
    ctrl_o.flag_ld   = flag_ld_i;
    ctrl_o.act_ld    = act_ld_i;
    ctrl_o.carry_clr = carry_clr_i;
    case (alu_op_i)
      OP_AND:  ctrl_o.fn = FN_AND;
      OP_OR:   ctrl_o.fn = FN_OR;
      OP_XOR:  ctrl_o.fn = FN_XOR;
      OP_ADD:  ctrl_o.is_add = 1'b1;
      OP_EXT:  ctrl_o.sel_ext = 1'b1;
      default: ctrl_o.fn = FN_A;
    endcase
  end
endmodule

// File: rtl/simd_bitmem.sv
module simd_bitmem #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic              q_o
);
  logic mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= d_i;
  end

  assign q_o = mem_q[addr_i];
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned IND_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pe_ctrl_t          ctrl_i,
  input  logic [ADDR_W-1:0] gaddr_i,
  input  logic              ext_i,
  output logic              rd_o,
  output logic              res_o,
  output logic              act_o
);
  logic [IND_W-1:0]  ind_q;
  logic              carry_q, flag_q, act_q;
  logic [ADDR_W-1:0] ind_addr, eff_addr;
  logic              op_a, op_b, fn_res, carry_nxt;

  // only the low address bits of the register reach the memory
  assign ind_addr = ind_q[ADDR_W-1:0];
  assign eff_addr = !ctrl_i.use_ind ? gaddr_i :
                    ctrl_i.add_glob ? ADDR_W'(gaddr_i + ind_addr) : ind_addr;

  simd_bitmem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i (clk_i),
    .we_i  (ctrl_i.we & act_q),
    .addr_i(eff_addr),
    .d_i   (res_o),
    .q_o   (rd_o)
  );

  assign op_a = ctrl_i.sel_ext ? ext_i : rd_o;
  assign op_b = flag_q;

  always_comb begin
    case (ctrl_i.fn)
      FN_AND:  fn_res = op_a & op_b;
      FN_OR:   fn_res = op_a | op_b;
      FN_XOR:  fn_res = op_a ^ op_b;
      default: fn_res = op_a;
    endcase
  end

  assign res_o     = ctrl_i.is_add ? (op_a ^ op_b ^ carry_q) : fn_res;
  assign carry_nxt = (op_a & op_b) | (op_a & carry_q) | (op_b & carry_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ind_q   <= '0;
      carry_q <= 1'b0;
      flag_q  <= 1'b0;
      act_q   <= 1'b1;
    end else begin
      if (ctrl_i.act_ld) act_q <= res_o;
      if (ctrl_i.carry_clr)                carry_q <= 1'b0;
      else if (ctrl_i.is_add && act_q)     carry_q <= carry_nxt;
      if (act_q && ctrl_i.flag_ld) flag_q <= res_o;
      if (act_q && ctrl_i.shift)   ind_q  <= {res_o, ind_q[IND_W-1:1]};
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/simd_ind_array.sv
module simd_ind_array
  import simd_pkg::*;
#(
  parameter int unsigned NUM_PE    = 4,
  parameter int unsigned MEM_DEPTH = 1024,
  parameter int unsigned ADDR_W    = $clog2(MEM_DEPTH),
  parameter int unsigned IND_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        alu_op_i,
  input  logic [1:0]        addr_mode_i,
  input  logic [ADDR_W-1:0] gaddr_i,
  input  logic              mem_we_i,
  input  logic              ind_shift_i,
  input  logic              flag_ld_i,
  input  logic              act_ld_i,
  input  logic              carry_clr_i,
  input  logic [NUM_PE-1:0] ext_i,
  output logic [NUM_PE-1:0] rd_o,
  output logic [NUM_PE-1:0] res_o,
  output logic [NUM_PE-1:0] act_o
);
  pe_ctrl_t ctrl;

  simd_decode u_dec (
    .alu_op_i   (alu_op_i),
    .addr_mode_i(addr_mode_i),
    .mem_we_i   (mem_we_i),
    .ind_shift_i(ind_shift_i),
    .flag_ld_i  (flag_ld_i),
    .act_ld_i   (act_ld_i),
    .carry_clr_i(carry_clr_i),
    .ctrl_o     (ctrl)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    simd_pe #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W), .IND_W(IND_W)) u_pe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl),
      .gaddr_i(gaddr_i),
      .ext_i  (ext_i[g]),
      .rd_o   (rd_o[g]),
      .res_o  (res_o[g]),
      .act_o  (act_o[g])
    );
  end
endmodule

// File: rtl/simd_ind_array_chk.sv
module simd_ind_array_chk
  import simd_pkg::*;
#(
  parameter int unsigned NUM_PE = 4,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        alu_op_i,
  input logic [1:0]        addr_mode_i,
  input logic [ADDR_W-1:0] gaddr_i,
  input logic              mem_we_i,
  input logic              act_ld_i,
  input logic [NUM_PE-1:0] ext_i,
  input logic [NUM_PE-1:0] rd_o,
  input logic [NUM_PE-1:0] res_o,
  input logic [NUM_PE-1:0] act_o
);
  for (genvar g = 0; g < NUM_PE; g++) begin : g_chk
    a_r9_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_ld_i |=> $stable(act_o[g]));

    a_r6_pass_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alu_op_i == OP_PASS) |-> (res_o[g] == rd_o[g]));

    a_r11_ext_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alu_op_i == OP_EXT) |-> (res_o[g] == ext_i[g]));

    a_r10_wr_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_i && act_o[g] && addr_mode_i == AM_GLOBAL) ##1
      (addr_mode_i == AM_GLOBAL && gaddr_i == $past(gaddr_i))
      |-> (rd_o[g] == $past(res_o[g])));
  end
endmodule

bind simd_ind_array simd_ind_array_chk #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alu_op_i   (alu_op_i),
  .addr_mode_i(addr_mode_i),
  .gaddr_i    (gaddr_i),
  .mem_we_i   (mem_we_i),
  .act_ld_i   (act_ld_i),
  .ext_i      (ext_i),
  .rd_o       (rd_o),
  .res_o      (res_o),
  .act_o      (act_o)
);

// File: tb/simd_ind_array_tb.sv
module simd_ind_array_tb;
  localparam int CLK_P = 10;
  localparam int NPE   = 4;
  localparam int DEP   = 1024;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     op = '0;
  logic [1:0]     md = '0;
  logic [9:0]     ga = '0;
  logic           we = 1'b0, sh = 1'b0, fl = 1'b0, al = 1'b0, cc = 1'b0;
  logic [NPE-1:0] ex = '0;
  logic [NPE-1:0] rd, res, act;

  int n_cmp = 0;
  int n_bad = 0;

  bit          mem_m [NPE][DEP];
  bit          val_m [NPE][DEP];
  logic [15:0] ind_m [NPE];
  bit          car_m [NPE], flg_m [NPE], act_m [NPE];

  always #(CLK_P/2) clk = ~clk;

  simd_ind_array #(.NUM_PE(NPE), .MEM_DEPTH(DEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .alu_op_i(op), .addr_mode_i(md), .gaddr_i(ga),
    .mem_we_i(we), .ind_shift_i(sh), .flag_ld_i(fl), .act_ld_i(al),
    .carry_clr_i(cc), .ext_i(ex), .rd_o(rd), .res_o(res), .act_o(act)
  );

  function automatic bit pat(int p, int a);
    return ((a * 5 + p * 3 + (a >> 2) + p * a) % 3) == 0;
  endfunction

  task automatic chk(string tag, logic got, logic exp, int p);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pe%0d t=%0t got=%b exp=%b", tag, p, $time, got, exp);
    end
  endtask

  // one broadcast instruction: drive, compare against the model, then advance the model
  task automatic step(input logic [2:0] o, input logic [1:0] m, input int a,
                      input bit w, input bit s, input bit f, input bit l, input bit c,
                      input logic [NPE-1:0] e);
    int  ea [NPE];
    bit  rs [NPE];
    bit  av [NPE];
    @(negedge clk);
    op = o; md = m; ga = a[9:0]; we = w; sh = s; fl = f; al = l; cc = c; ex = e;
    #(CLK_P/4);
    for (int p = 0; p < NPE; p++) begin
      bit va, b;
      int il;
      il = int'(ind_m[p][9:0]);
      ea[p] = (m == 2'd1) ? il : (m == 2'd2) ? ((a + il) % DEP) : a;
      va = (o == 3'd5) ? e[p] : mem_m[p][ea[p]];
      av[p] = (o == 3'd5) || val_m[p][ea[p]];
      b  = flg_m[p];
      case (o)
        3'd1: rs[p] = va & b;
        3'd2: rs[p] = va | b;
        3'd3: rs[p] = va ^ b;
        3'd4: rs[p] = va ^ b ^ car_m[p];
        default: rs[p] = va;
      endcase
      if (val_m[p][ea[p]])
        chk((m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R2", rd[p], mem_m[p][ea[p]], p);
      if (av[p]) chk((o == 3'd4) ? "R7" : (o == 3'd5) ? "R11" : "R6", res[p], rs[p], p);
      chk("R9", act[p], act_m[p], p);
      if (c) car_m[p] = 1'b0;
      else if (o == 3'd4 && act_m[p] && av[p] && val_m[p][ea[p]] | (o == 3'd5))
        car_m[p] = (va & b) | (va & car_m[p]) | (b & car_m[p]);
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < NPE; p++) begin
      if (act_m[p]) begin
        if (w) begin mem_m[p][ea[p]] = rs[p]; val_m[p][ea[p]] = av[p]; end
        if (s) ind_m[p] = {rs[p], ind_m[p][15:1]};
        if (f) flg_m[p] = rs[p];
      end
      if (l) act_m[p] = rs[p];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] idx [NPE];
    logic [NPE-1:0] e;
    for (int p = 0; p < NPE; p++) begin
      ind_m[p] = '0; car_m[p] = 0; flg_m[p] = 0; act_m[p] = 1;
      for (int a = 0; a < DEP; a++) begin mem_m[p][a] = 0; val_m[p][a] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: every element active out of reset
    @(negedge clk);
    for (int p = 0; p < NPE; p++) chk("R1", act[p], 1'b1, p);

    // fill every memory plane with a per-element pattern (R11, R10)
    for (int a = 0; a < DEP; a++) begin
      for (int p = 0; p < NPE; p++) e[p] = pat(p, a);
      step(3'd5, 2'd0, a, 1, 0, 0, 0, 0, e);
    end
    // R2: global reads at several addresses
    foreach (idx[k]) step(3'd0, 2'd0, 17 + k * 211, 0, 0, 0, 0, 0, '0);
    step(3'd7, 2'd3, 1023, 0, 0, 0, 0, 0, '0);
    // R1: cleared registers make replace mode read address 0
    step(3'd0, 2'd1, 555, 0, 0, 0, 0, 0, '0);

    // serialise a distinct index per element into addresses 1000..1015, then shift it in (R5)
    for (int p = 0; p < NPE; p++) idx[p] = 16'hC000 | 16'(50 + p * 301);
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < NPE; p++) e[p] = idx[p][k];
      step(3'd5, 2'd0, 1000 + k, 1, 0, 0, 0, 0, e);
    end
    for (int k = 0; k < 16; k++) step(3'd0, 2'd0, 1000 + k, 0, 1, 0, 0, 0, '0);
    // R3: indirect read with upper register bits set; R4: offset reads incl. wrap
    step(3'd0, 2'd1, 0, 0, 0, 0, 0, 0, '0);
    step(3'd0, 2'd2, 200, 0, 0, 0, 0, 0, '0);
    step(3'd0, 2'd2, 900, 0, 0, 0, 0, 0, '0);
    // R10: indirect write then read back
    step(3'd5, 2'd1, 0, 1, 0, 0, 0, 0, 4'b1010);
    step(3'd0, 2'd1, 0, 0, 0, 0, 0, 0, '0);

    // R9: mask half the elements, then try writes, shifts and flag loads
    step(3'd5, 2'd0, 0, 0, 0, 0, 1, 0, 4'b0101);
    step(3'd5, 2'd0, 7, 1, 0, 1, 0, 0, 4'b1111);
    step(3'd0, 2'd0, 7, 0, 0, 0, 0, 0, '0);
    step(3'd5, 2'd0, 0, 0, 1, 0, 0, 0, 4'b1111);
    step(3'd0, 2'd1, 0, 0, 0, 0, 0, 0, '0);
    step(3'd5, 2'd0, 0, 0, 0, 0, 1, 0, 4'b1111);

    // R8 and R7: load flag, chained adds, clear
    step(3'd5, 2'd0, 0, 0, 0, 1, 0, 1, 4'b1111);
    step(3'd4, 2'd0, 3, 0, 0, 0, 0, 0, '0);
    step(3'd4, 2'd0, 3, 0, 0, 0, 0, 0, '0);
    step(3'd4, 2'd0, 4, 0, 0, 0, 0, 1, '0);
    step(3'd4, 2'd0, 4, 0, 0, 0, 0, 0, '0);

    // mixed instruction stream
    for (int i = 0; i < 600; i++) begin
      bit l;
      l = ($urandom % 8) == 0;
      step(3'($urandom % 8), 2'($urandom % 4), int'($urandom % DEP), 1'($urandom),
           1'($urandom), 1'($urandom), l, ($urandom % 8) == 0, NPE'($urandom));
      if (l && act_m[0] == 0 && act_m[1] == 0 && act_m[2] == 0 && act_m[3] == 0)
        step(3'd5, 2'd0, 0, 0, 0, 0, 1, 0, 4'b1111);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule